// File: doc/BRIEF.md
# Keyed Configuration Byte Port

This peripheral hands a small table of configuration items to boot firmware one byte at a time. Firmware writes a 16-bit key to the selector register at address 0. The key picks one item from one of two banks, a generic bank and an architecture-local bank. Each access to the data register at address 1 then moves through that item's bytes. An internal offset advances after every byte that is delivered. Invalid keys, empty items and reads beyond the item's length all return zero and leave the offset where it is.

Items whose key carries the write-channel flag can also be filled by firmware. Each accepted data write stores one byte and advances the offset. The write that makes the offset reach the item's length raises a one-cycle completion pulse, reports the bank and index of that item, and rewinds the offset to zero.

Before firmware runs, a host-side preload port sets the item bytes and the 16-bit item lengths. After reset two items are already present: a 4-byte ASCII signature in generic entry 0, and a 32-bit identifier of value 1 in generic entry 1.

A small state machine drives the response outputs. It has three states:
- ST_IDLE: no response is pending.
- ST_READ_RESP: read data is valid. The machine enters this state after any read.
- ST_WRITE_DONE: the completion pulse is high. The machine enters this state after a write that filled an item.

Each state is entered from any state, and at each clock edge the machine leaves it again for whichever state the access in that cycle calls for. An edge that carries no read and no filling write goes to ST_IDLE.

Top module: `cfgp_port`

## Requirements
- R1: A write to address 0 (with reg_rd low) loads reg_wdata as the current key and clears the offset to zero. The next data read returns byte 0 of the newly selected item.
- R2: In a key, bit 15 selects the architecture-local bank (1) or the generic bank (0). Bit 14 marks a write-channel item. Bits 13:0 hold the entry index, and each bank has N_ENTRIES entries (default 16). The same index in the two banks names two separate items.
- R3: If a written key has bits 13:0 at N_ENTRIES or above, the current key becomes 16'hFFFF. Data reads under that key return 8'h00, and data writes under it are ignored.
- R4: A read (reg_rd high) sets reg_rvalid high for exactly the following cycle. A read of address 1 returns the item byte at the current offset and then increments the offset. A read of address 0 returns 8'h00 and leaves the offset unchanged.
- R5: When the item's length is 0, or the offset has reached the length, a data read returns 8'h00 and leaves the offset unchanged.
- R6: A data write (reg_wr high, reg_addr 1) is accepted only when the key is valid, key bit 14 is 1, and the offset is below the length. An accepted write stores reg_wdata[7:0] at the offset and increments the offset. Any other data write changes neither the offset nor the stored bytes.
- R7: When an accepted write makes the offset equal to the length, done_pulse is high for the following cycle, with done_bank and done_index naming the item. The offset then becomes 0.
- R8: After reset the key is 0 and the offset is 0. Generic entry 0 holds 4 bytes, the signature characters first character first (default "CFGP", that is 43 46 47 50). Generic entry 1 holds 4 bytes, DEVICE_ID least significant byte first (default 01 00 00 00).
- R9: The preload port writes pl_byte to the byte at (pl_bank, pl_index, pl_offset) when pl_byte_we is high, and writes pl_len as that item's length when pl_len_we is high.
- R10: When reg_rd and reg_wr are high in the same cycle, the read is served and the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = selector, 1 = data |
| reg_wdata | input | 16 | Key (selector) or byte in bits 7:0 (data) |
| reg_rdata | output | 8 | Read data, valid while reg_rvalid is high |
| reg_rvalid | output | 1 | Read response valid |
| pl_byte_we | input | 1 | Preload byte write enable |
| pl_len_we | input | 1 | Preload length write enable |
| pl_bank | input | 1 | Preload bank |
| pl_index | input | IDX_W | Preload entry index |
| pl_offset | input | OFF_W | Preload byte position |
| pl_byte | input | 8 | Preload byte value |
| pl_len | input | 16 | Preload item length |
| done_pulse | output | 1 | Write-channel item completed |
| done_bank | output | 1 | Bank of the completed item |
| done_index | output | IDX_W | Index of the completed item |

## Verification
The streaming function is tested with several key patterns:
- The reset-time signature and identifier are streamed all the way past their end. This separates a correct order and length from an off-by-one stop.
- The same index is selected in both banks, which shows whether bit 15 really picks a separate item.
- A mid-stream reselect and an intervening selector read show whether only selector writes rewind the offset.
- A writable item is filled and then read back. This tells a completion on the final byte apart from an early or missing one, and shows the rewind.
- Writes to a read-only key, writes to an invalid key, and a combined read and write in one cycle all confirm that the data write is ignored in those cases.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int KEY_W = 16;
    localparam int LEN_W = 16;
    localparam logic [KEY_W-1:0] KEY_NONE = 16'hFFFF;
    localparam int BANK_BIT = 15;
    localparam int WCH_BIT  = 14;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_READ_RESP  = 2'd1,
        ST_WRITE_DONE = 2'd2
    } port_state_e;
endpackage

// File: rtl/cfgp_store.sv
module cfgp_store #(
    parameter int N_ENTRIES   = 16,
    parameter int ENTRY_BYTES = 16,
    parameter int IDX_W       = 4,
    parameter int OFF_W       = 4,
    parameter logic [31:0] SIGNATURE = 32'h43464750,
    parameter logic [31:0] DEVICE_ID = 32'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cur_bank,
    input  logic [IDX_W-1:0] cur_index,
    input  logic [OFF_W-1:0] cur_off,
    output logic [7:0]       cur_byte,
    output logic [15:0]      cur_len,
    input  logic             fw_we,
    input  logic [7:0]       fw_byte,
    input  logic             pl_byte_we,
    input  logic             pl_len_we,
    input  logic             pl_bank,
    input  logic [IDX_W-1:0] pl_index,
    input  logic [OFF_W-1:0] pl_offset,
    input  logic [7:0]       pl_byte,
    input  logic [15:0]      pl_len
);
    logic [7:0]  mem   [2][N_ENTRIES][ENTRY_BYTES];
    logic [15:0] len_q [2][N_ENTRIES];
    logic        idx_ok;

    generate
        if (N_ENTRIES == (1 << IDX_W)) begin : g_full
            assign idx_ok = 1'b1;
        end else begin : g_part
            assign idx_ok = (32'(cur_index) < N_ENTRIES);
        end
    endgenerate

    assign cur_byte = idx_ok ? mem[cur_bank][cur_index][cur_off] : 8'h00;
    assign cur_len  = idx_ok ? len_q[cur_bank][cur_index] : 16'h0000;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                for (int i = 0; i < N_ENTRIES; i++) begin
                    len_q[b][i] <= 16'h0000;
                    for (int k = 0; k < ENTRY_BYTES; k++) begin
                        mem[b][i][k] <= 8'h00;
                    end
                end
            end
            for (int k = 0; k < 4; k++) begin
                mem[0][0][k] <= SIGNATURE[31-8*k -: 8];
                mem[0][1][k] <= DEVICE_ID[8*k +: 8];
            end
            len_q[0][0] <= 16'd4;
            len_q[0][1] <= 16'd4;
        end else begin
            if (fw_we && idx_ok) begin
                mem[cur_bank][cur_index][cur_off] <= fw_byte;
            end
            if (pl_byte_we) begin
                mem[pl_bank][pl_index][pl_offset] <= pl_byte;
            end
            if (pl_len_we) begin
                len_q[pl_bank][pl_index] <= pl_len;
            end
        end
    end
endmodule

// File: rtl/cfgp_cursor.sv
module cfgp_cursor
    import cfgp_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic [KEY_W-1:0] sel_key,
    input  logic             dat_rd,
    input  logic             dat_wr,
    input  logic [LEN_W-1:0] len_cur,
    output logic [KEY_W-1:0] key_q,
    output logic [LEN_W-1:0] off_q,
    output logic             rd_hit,
    output logic             wr_hit,
    output logic             wr_last
);
    logic key_ok;
    logic in_range;

    assign key_ok   = (key_q != KEY_NONE);
    assign in_range = (off_q < len_cur);
    assign rd_hit   = dat_rd && key_ok && in_range;
    assign wr_hit   = dat_wr && key_ok && key_q[WCH_BIT] && in_range;
    assign wr_last  = wr_hit && (LEN_W'(off_q + 1'b1) == len_cur);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
            off_q <= '0;
        end else if (sel_we) begin
            key_q <= (32'(sel_key[13:0]) >= N_ENTRIES) ? KEY_NONE : sel_key;
            off_q <= '0;
        end else if (rd_hit) begin
            off_q <= LEN_W'(off_q + 1'b1);
        end else if (wr_hit) begin
            off_q <= wr_last ? '0 : LEN_W'(off_q + 1'b1);
        end
    end
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
    import cfgp_pkg::*;
#(
    parameter int N_ENTRIES   = 16,
    parameter int ENTRY_BYTES = 16,
    parameter logic [31:0] SIGNATURE = 32'h43464750,
    parameter logic [31:0] DEVICE_ID = 32'd1,
    parameter int IDX_W = $clog2(N_ENTRIES),
    parameter int OFF_W = $clog2(ENTRY_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             reg_rvalid,
    input  logic             pl_byte_we,
    input  logic             pl_len_we,
    input  logic             pl_bank,
    input  logic [IDX_W-1:0] pl_index,
    input  logic [OFF_W-1:0] pl_offset,
    input  logic [7:0]       pl_byte,
    input  logic [15:0]      pl_len,
    output logic             done_pulse,
    output logic             done_bank,
    output logic [IDX_W-1:0] done_index
);
    port_state_e state_q, state_d;

    logic             sel_we, dat_rd, dat_wr;
    logic [KEY_W-1:0] key_cur;
    logic [LEN_W-1:0] off_cur, len_cur;
    logic             rd_hit, wr_hit, wr_last;
    logic [7:0]       cur_byte;
    logic [7:0]       rdata_q;
    logic             dbank_q;
    logic [IDX_W-1:0] dindex_q;

    // A read in the same cycle suppresses any write
    assign sel_we = reg_wr && !reg_rd && !reg_addr;
    assign dat_wr = reg_wr && !reg_rd &&  reg_addr;
    assign dat_rd = reg_rd && reg_addr;

    cfgp_cursor #(.N_ENTRIES(N_ENTRIES)) u_cursor (
        .clk(clk), .rst_n(rst_n),
        .sel_we(sel_we), .sel_key(reg_wdata),
        .dat_rd(dat_rd), .dat_wr(dat_wr), .len_cur(len_cur),
        .key_q(key_cur), .off_q(off_cur),
        .rd_hit(rd_hit), .wr_hit(wr_hit), .wr_last(wr_last)
    );

    cfgp_store #(
        .N_ENTRIES(N_ENTRIES), .ENTRY_BYTES(ENTRY_BYTES),
        .IDX_W(IDX_W), .OFF_W(OFF_W),
        .SIGNATURE(SIGNATURE), .DEVICE_ID(DEVICE_ID)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .cur_bank(key_cur[BANK_BIT]),
        .cur_index(key_cur[IDX_W-1:0]),
        .cur_off(off_cur[OFF_W-1:0]),
        .cur_byte(cur_byte), .cur_len(len_cur),
        .fw_we(wr_hit), .fw_byte(reg_wdata[7:0]),
        .pl_byte_we(pl_byte_we), .pl_len_we(pl_len_we),
        .pl_bank(pl_bank), .pl_index(pl_index), .pl_offset(pl_offset),
        .pl_byte(pl_byte), .pl_len(pl_len)
    );

    // Next-state choice: a read wins, then a filling write
    always_comb begin
        if (reg_rd)       state_d = ST_READ_RESP;
        else if (wr_last) state_d = ST_WRITE_DONE;
        else              state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= 8'h00;
            dbank_q  <= 1'b0;
            dindex_q <= '0;
        end else begin
            if (reg_rd) rdata_q <= rd_hit ? cur_byte : 8'h00;
            if (wr_last) begin
                dbank_q  <= key_cur[BANK_BIT];
                dindex_q <= key_cur[IDX_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rvalid = 1'b0;
        reg_rdata  = 8'h00;
        done_pulse = 1'b0;
        done_bank  = 1'b0;
        done_index = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ_RESP: begin
                reg_rvalid = 1'b1;
                reg_rdata  = rdata_q;
            end
            ST_WRITE_DONE: begin
                done_pulse = 1'b1;
                done_bank  = dbank_q;
                done_index = dindex_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cfgp_port_chk.sv
module cfgp_port_chk #(
    parameter int N_ENTRIES = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_rd,
    input logic        reg_wr,
    input logic        reg_addr,
    input logic [15:0] reg_wdata,
    input logic [7:0]  reg_rdata,
    input logic        reg_rvalid,
    input logic        done_pulse,
    input logic [15:0] key_cur,
    input logic [15:0] off_cur,
    input logic [15:0] len_cur
);
    p_sel_clears_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && !reg_addr) |=> (off_cur == 16'h0));

    p_bad_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && !reg_addr && (32'(reg_wdata[13:0]) >= N_ENTRIES))
        |=> (key_cur == 16'hFFFF));

    p_none_key_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr && key_cur == 16'hFFFF)
        |=> (reg_rdata == 8'h00 && $stable(off_cur)));

    p_rvalid_after_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    p_no_rvalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

    p_past_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr && off_cur >= len_cur)
        |=> (reg_rdata == 8'h00 && $stable(off_cur)));

    p_ro_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && reg_addr && !key_cur[14])
        |=> ($stable(off_cur) && !done_pulse));

    p_done_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (off_cur == 16'h0));

    p_both_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_wr) |=> !done_pulse);
endmodule

bind cfgp_port cfgp_port_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .done_pulse(done_pulse),
    .key_cur(key_cur), .off_cur(off_cur), .len_cur(len_cur)
);

// File: tb/cfgp_port_bench.sv
module cfgp_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [7:0]  reg_rdata;
    logic        reg_rvalid;
    logic        pl_byte_we = 1'b0, pl_len_we = 1'b0, pl_bank = 1'b0;
    logic [3:0]  pl_index = 4'h0, pl_offset = 4'h0;
    logic [7:0]  pl_byte = 8'h0;
    logic [15:0] pl_len = 16'h0;
    logic        done_pulse, done_bank;
    logic [3:0]  done_index;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cfgp_port u_cfgp_port (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .pl_byte_we(pl_byte_we), .pl_len_we(pl_len_we),
        .pl_bank(pl_bank), .pl_index(pl_index), .pl_offset(pl_offset),
        .pl_byte(pl_byte), .pl_len(pl_len), .done_pulse(done_pulse),
        .done_bank(done_bank), .done_index(done_index)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sel(input logic [15:0] key);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = key;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic addr, output logic [7:0] d, output logic v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = addr;
        @(negedge clk);
        d = reg_rdata; v = reg_rvalid;
        reg_rd = 1'b0;
    endtask

    task automatic expect_byte(input string req, input logic [7:0] exp);
        logic [7:0] d; logic v;
        rd(1'b1, d, v);
        check(req, {23'h0, v, d}, {23'h0, 1'b1, exp});
    endtask

    task automatic wr(input logic [7:0] b, output logic dp, output logic db, output logic [3:0] di);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = {8'h00, b};
        @(negedge clk);
        dp = done_pulse; db = done_bank; di = done_index;
        reg_wr = 1'b0;
    endtask

    task automatic preload(input logic bank, input logic [3:0] idx, input logic [15:0] len,
                           input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        logic [7:0] bytes [3];
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            pl_byte_we = 1'b1; pl_bank = bank; pl_index = idx;
            pl_offset = 4'(k); pl_byte = bytes[k];
        end
        @(negedge clk);
        pl_byte_we = 1'b0; pl_len_we = 1'b1; pl_len = len;
        @(negedge clk);
        pl_len_we = 1'b0;
    endtask

    task automatic t_reset_signature();
        expect_byte("R8 sig0", 8'h43);
        expect_byte("R8 sig1", 8'h46);
        expect_byte("R8 sig2", 8'h47);
        expect_byte("R8 sig3", 8'h50);
        expect_byte("R5 past end", 8'h00);
        expect_byte("R5 past end again", 8'h00);
    endtask

    task automatic t_identifier();
        sel(16'h0001);
        expect_byte("R8 id0", 8'h01);
        expect_byte("R8 id1", 8'h00);
        expect_byte("R8 id2", 8'h00);
        expect_byte("R8 id3", 8'h00);
        expect_byte("R5 id end", 8'h00);
    endtask

    task automatic t_reselect();
        logic [7:0] d; logic v;
        sel(16'h0000);
        expect_byte("R1 first", 8'h43);
        rd(1'b0, d, v);
        check("R4 selector read", {23'h0, v, d}, {23'h0, 1'b1, 8'h00});
        expect_byte("R4 offset kept", 8'h46);
        sel(16'h0000);
        expect_byte("R1 rewind", 8'h43);
    endtask

    task automatic t_invalid();
        logic dp, db; logic [3:0] di;
        sel(16'h0010);
        expect_byte("R3 index 16", 8'h00);
        sel(16'hFFFF);
        wr(8'h99, dp, db, di);
        check("R3 write ignored", {31'h0, dp}, 32'h0);
        expect_byte("R3 still zero", 8'h00);
    endtask

    task automatic t_banks();
        preload(1'b1, 4'd2, 16'd2, 8'hAA, 8'hBB, 8'hCC);
        preload(1'b0, 4'd2, 16'd1, 8'h11, 8'h12, 8'h13);
        sel(16'h8002);
        expect_byte("R2 R9 arch b0", 8'hAA);
        expect_byte("R2 R9 arch b1", 8'hBB);
        expect_byte("R9 length honoured", 8'h00);
        sel(16'h0002);
        expect_byte("R2 generic b0", 8'h11);
        expect_byte("R5 generic end", 8'h00);
        sel(16'h0007);
        expect_byte("R5 empty", 8'h00);
    endtask

    task automatic t_fill();
        logic dp, db; logic [3:0] di;
        preload(1'b1, 4'd5, 16'd3, 8'h00, 8'h00, 8'h00);
        sel(16'hC005);
        wr(8'h21, dp, db, di);
        check("R7 no early done 1", {31'h0, dp}, 32'h0);
        wr(8'h22, dp, db, di);
        check("R7 no early done 2", {31'h0, dp}, 32'h0);
        wr(8'h23, dp, db, di);
        check("R7 done fields", {26'h0, dp, db, di}, {26'h0, 1'b1, 1'b1, 4'd5});
        @(negedge clk);
        check("R7 one cycle", {31'h0, done_pulse}, 32'h0);
        expect_byte("R6 R7 rewind b0", 8'h21);
        expect_byte("R6 stored b1", 8'h22);
        expect_byte("R6 stored b2", 8'h23);
        wr(8'h77, dp, db, di);
        check("R6 past length ignored", {31'h0, dp}, 32'h0);
        expect_byte("R5 fill end", 8'h00);
    endtask

    task automatic t_readonly();
        logic dp, db; logic [3:0] di;
        preload(1'b0, 4'd5, 16'd2, 8'h77, 8'h88, 8'h00);
        sel(16'h0005);
        wr(8'h55, dp, db, di);
        check("R6 ro no done", {31'h0, dp}, 32'h0);
        expect_byte("R6 ro unchanged", 8'h77);
        expect_byte("R6 ro next", 8'h88);
    endtask

    task automatic t_both();
        preload(1'b0, 4'd9, 16'd1, 8'h5A, 8'h00, 8'h00);
        sel(16'h4009);
        @(negedge clk);
        reg_rd = 1'b1; reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 16'h0033;
        @(negedge clk);
        check("R10 read served", {23'h0, reg_rvalid, reg_rdata}, {23'h0, 1'b1, 8'h5A});
        check("R10 no done", {31'h0, done_pulse}, 32'h0);
        reg_rd = 1'b0; reg_wr = 1'b0;
        sel(16'h4009);
        expect_byte("R10 byte kept", 8'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 no rvalid after reset", {31'h0, reg_rvalid}, 32'h0);
        check("R7 no done after reset", {31'h0, done_pulse}, 32'h0);
        t_reset_signature();
        t_identifier();
        t_reselect();
        t_invalid();
        t_banks();
        t_fill();
        t_readonly();
        t_both();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule